// File: doc/BRIEF.md
# Synchronous Two-Port Memory Model

This block is a clocked memory with two symmetric access ports, A and B, sharing a single clock. Each port presents an enable, a write strobe, an output-clear strobe, an address and write data on every rising edge. It returns registered read data and a one-cycle collision flag. The storage array can only be observed through the per-port output registers, so every read has one clock of latency.

A port that writes also shows the value it just wrote on its own output. That is write-first behaviour. The output-clear strobe empties only that port's output register and leaves the array alone. When the two ports touch the same location in the same cycle in a conflicting way, the model marks the affected result as invalid (all-X) and raises the collision flag on the port concerned. Wrapper logic, such as cross-port bypass or read-port replication, can then be tested against a reference that makes those hazards visible.

Top module: `dpram_sync`

## Requirements
- R1: A port with enable=1, write=1 and clear=0 on a rising edge stores its write data at its address. A later read of that address from either port returns the stored value.
- R2: In the cycle after such a write, the writing port's read data equals the data it wrote (write-first on the same port).
- R3: A port with enable=1, write=0 and clear=0 places the contents of its address on its read data one clock later.
- R4: A port with enable=1 and clear=1 sets its read data to zero and its collision flag to 0 on the next clock. No write happens, whatever the write strobe, and the array contents are unchanged.
- R5: A port with enable=0 keeps its read data unchanged, drops its collision flag and performs no write.
- R6: When one port reads the address that the other port writes in the same cycle, the reader's data is invalid and the reader's collision flag is 1 in the next cycle. The write itself still completes.
- R7: When both ports write the same address in the same cycle, that location becomes invalid and both collision flags are 1 in the next cycle.
- R8: A collision flag is high for exactly the one cycle after a collision. Two ports reading the same address, or accesses to different addresses, raise no flag.
- R9: The synchronous active-high reset sets both read data outputs to zero and both collision flags to 0, and leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the output registers and flags |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write strobe |
| a_oclr | input | 1 | Port A output-register clear |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered read data |
| a_clash | output | 1 | Port A collision flag |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write strobe |
| b_oclr | input | 1 | Port B output-register clear |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B registered read data |
| b_clash | output | 1 | Port B collision flag |

## Verification
On every cycle, the assertions check the per-port control rules: write-first echo of the written data, the effect of clear, holding while disabled, the reset state, and the collision flags that follow a read-against-write or a write-against-write on a shared address. Only the bench scenarios can show what ends up in the array. That covers data written by one port and read back through the other, clear and disable suppressing a write, a colliding write still landing, and the contents surviving a reset. The invalid data value itself cannot be observed by the bench, so collisions are judged by their flags.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int NUM_PORTS = 2;

    // Operation a port performs on a given edge
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_CLR   = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } port_op_e;

    typedef struct packed {
        logic en;
        logic we;
        logic oclr;
    } port_ctl_t;

    // Clear has priority over write; disable has priority over both
    function automatic port_op_e decode_op(input port_ctl_t c);
        if (!c.en)      return OP_IDLE;
        else if (c.oclr) return OP_CLR;
        else if (c.we)   return OP_WRITE;
        else             return OP_READ;
    endfunction

endpackage

// File: rtl/dpram_collide.sv
module dpram_collide
    import dpram_pkg::*;
#(
    parameter int AW = 4
) (
    input  port_op_e       op   [NUM_PORTS],
    input  logic [AW-1:0]  addr [NUM_PORTS],
    output logic           hit  [NUM_PORTS],
    output logic           ww_hit
);
    logic same_loc;

    assign same_loc = (addr[0] == addr[1]);
    assign ww_hit   = same_loc && (op[0] == OP_WRITE) && (op[1] == OP_WRITE);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        localparam int OTHER = NUM_PORTS - 1 - p;
        assign hit[p] = ww_hit ||
                        (same_loc && (op[p] == OP_READ) && (op[OTHER] == OP_WRITE));
    end
endmodule

// File: rtl/dpram_store.sv
module dpram_store
    import dpram_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic           clk,
    input  port_op_e       op    [NUM_PORTS],
    input  logic [AW-1:0]  addr  [NUM_PORTS],
    input  logic [DW-1:0]  wdata [NUM_PORTS],
    input  logic           ww_hit,
    output logic [DW-1:0]  rq    [NUM_PORTS]
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (op[p] == OP_WRITE)
                mem[addr[p]] <= ww_hit ? {DW{1'bx}} : wdata[p];
        end
    end

    // Array tap feeding the output registers only
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tap
        assign rq[p] = mem[addr[p]];
    end
endmodule

// File: rtl/dpram_outreg.sv
module dpram_outreg
    import dpram_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  port_op_e      op,
    input  logic          hit,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rq,
    output logic [DW-1:0] dout,
    output logic          clash
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            clash <= 1'b0;
        end else begin
            unique case (op)
                OP_IDLE: clash <= 1'b0;
                OP_CLR: begin
                    dout  <= '0;
                    clash <= 1'b0;
                end
                OP_WRITE: begin
                    dout  <= wdata;
                    clash <= hit;
                end
                OP_READ: begin
                    dout  <= hit ? {DW{1'bx}} : rq;
                    clash <= hit;
                end
                default: clash <= 1'b0;
            endcase
        end
    end

    // R2
    write_first_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |=> (dout == $past(wdata)));

    // R4
    clear_out_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR) |=> (dout == '0 && !clash));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> ($stable(dout) && !clash));
endmodule

// File: rtl/dpram_sync.sv
module dpram_sync
    import dpram_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_en,
    input  logic          a_we,
    input  logic          a_oclr,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_clash,
    input  logic          b_en,
    input  logic          b_we,
    input  logic          b_oclr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_clash
);
    port_op_e      op_v    [NUM_PORTS];
    logic [AW-1:0] addr_v  [NUM_PORTS];
    logic [DW-1:0] wd_v    [NUM_PORTS];
    logic [DW-1:0] rq_v    [NUM_PORTS];
    logic [DW-1:0] dout_v  [NUM_PORTS];
    logic          hit_v   [NUM_PORTS];
    logic          clash_v [NUM_PORTS];
    logic          ww_hit;

    assign op_v[0]   = decode_op('{en: a_en, we: a_we, oclr: a_oclr});
    assign op_v[1]   = decode_op('{en: b_en, we: b_we, oclr: b_oclr});
    assign addr_v[0] = a_addr;
    assign addr_v[1] = b_addr;
    assign wd_v[0]   = a_wdata;
    assign wd_v[1]   = b_wdata;

    dpram_collide #(.AW(AW)) u_collide (
        .op     (op_v),
        .addr   (addr_v),
        .hit    (hit_v),
        .ww_hit (ww_hit)
    );

    dpram_store #(.DW(DW), .AW(AW)) u_store (
        .clk    (clk),
        .op     (op_v),
        .addr   (addr_v),
        .wdata  (wd_v),
        .ww_hit (ww_hit),
        .rq     (rq_v)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpram_outreg #(.DW(DW)) u_outreg (
            .clk   (clk),
            .rst   (rst),
            .op    (op_v[p]),
            .hit   (hit_v[p]),
            .wdata (wd_v[p]),
            .rq    (rq_v[p]),
            .dout  (dout_v[p]),
            .clash (clash_v[p])
        );
    end

    assign a_rdata = dout_v[0];
    assign b_rdata = dout_v[1];
    assign a_clash = clash_v[0];
    assign b_clash = clash_v[1];

    // R6
    a_read_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && !a_we && !a_oclr && b_en && b_we && !b_oclr && a_addr == b_addr)
        |=> a_clash);

    // R6
    b_read_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (b_en && !b_we && !b_oclr && a_en && a_we && !a_oclr && a_addr == b_addr)
        |=> b_clash);

    // R7
    dual_write_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we && !a_oclr && b_en && b_we && !b_oclr && a_addr == b_addr)
        |=> (a_clash && b_clash));

    // R8
    no_shared_loc_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (a_addr != b_addr) |=> (!a_clash && !b_clash));

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (1'b0)
        rst |=> (a_rdata == '0 && b_rdata == '0 && !a_clash && !b_clash));
endmodule

// File: tb/dpram_sync_bench.sv
`timescale 1ns/1ps
module dpram_sync_bench;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst;
    logic a_en, a_we, a_oclr, b_en, b_we, b_oclr;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic a_clash, b_clash;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dpram_sync #(.DW(DW), .AW(AW)) u_dpram_sync (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_oclr(a_oclr), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_clash(a_clash),
        .b_en(b_en), .b_we(b_we), .b_oclr(b_oclr), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_clash(b_clash)
    );

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'(a * 13 + 7);
    endfunction
    function automatic logic [DW-1:0] pat2(input int a);
        return DW'(a * 29 + 64);
    endfunction
    function automatic logic [DW-1:0] pat3(input int a);
        return ~DW'(a * 5);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drv_a(input logic en, we, clr, input int addr, input logic [DW-1:0] d);
        a_en = en; a_we = we; a_oclr = clr; a_addr = AW'(addr); a_wdata = d;
    endtask
    task automatic drv_b(input logic en, we, clr, input int addr, input logic [DW-1:0] d);
        b_en = en; b_we = we; b_oclr = clr; b_addr = AW'(addr); b_wdata = d;
    endtask

    // inputs change at the falling edge; outputs are sampled at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(100000 * 5);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drv_a(0, 0, 0, 0, 0);
        drv_b(0, 0, 0, 0, 0);
        @(negedge clk);
        step(); step();
        // R9 reset state
        chk("R9 a_rdata reset", a_rdata, 0);
        chk("R9 b_rdata reset", b_rdata, 0);
        chk("R9 clash reset", {7'd0, a_clash | b_clash}, 0);
        rst = 1'b0;

        // R2 sweep: port A writes every location
        for (int i = 0; i < DEPTH; i++) begin
            drv_a(1, 1, 0, i, pat1(i));
            step();
            chk("R2 a write-first", a_rdata, pat1(i));
            chk("R8 a no clash on write", {7'd0, a_clash}, 0);
        end
        drv_a(0, 0, 0, 0, 0);

        // R1 R3 R8: both ports read the same location, data from earlier writes
        for (int i = 0; i < DEPTH; i++) begin
            drv_a(1, 0, 0, i, 0);
            drv_b(1, 0, 0, i, 0);
            step();
            chk("R1 b reads A data", b_rdata, pat1(i));
            chk("R3 a read", a_rdata, pat1(i));
            chk("R8 shared read no clash", {6'd0, a_clash, b_clash}, 0);
        end

        // R1 R2: both ports write different locations concurrently
        for (int i = 0; i < DEPTH; i++) begin
            drv_b(1, 1, 0, i, pat2(i));
            drv_a(1, 1, 0, i ^ 8, pat3(i ^ 8));
            step();
            chk("R2 b write-first", b_rdata, pat2(i));
            chk("R2 a write-first", a_rdata, pat3(i ^ 8));
            chk("R8 disjoint writes no clash", {6'd0, a_clash, b_clash}, 0);
        end
        drv_b(0, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            drv_a(1, 0, 0, i, 0);
            step();
            chk("R1 a reads concurrent writes", a_rdata, (i < 8) ? pat3(i) : pat2(i));
        end

        // R4: clear with write strobe set; output zero, no write
        drv_a(1, 1, 1, 3, 8'hFF);
        step();
        chk("R4 a clear output", a_rdata, 0);
        chk("R4 a clear flag", {7'd0, a_clash}, 0);
        drv_a(0, 0, 0, 0, 0);
        drv_b(1, 0, 0, 3, 0);
        step();
        chk("R4 clear keeps memory", b_rdata, pat3(3));

        // R5: disabled port holds output, no write
        drv_a(1, 0, 0, 5, 0);
        step();
        chk("R3 a read before hold", a_rdata, pat3(5));
        drv_a(0, 1, 0, 5, 8'hAA);
        drv_b(0, 0, 0, 0, 0);
        step(); step();
        chk("R5 a holds", a_rdata, pat3(5));
        drv_a(0, 0, 0, 0, 0);
        drv_b(1, 0, 0, 5, 0);
        step();
        chk("R5 disabled write ignored", b_rdata, pat3(5));

        // R6: A writes 9 while B reads 9
        drv_a(1, 1, 0, 9, 8'h5C);
        drv_b(1, 0, 0, 9, 0);
        step();
        chk("R6 reader clash", {7'd0, b_clash}, 1);
        chk("R6 writer not flagged", {7'd0, a_clash}, 0);
        chk("R2 writer echo during clash", a_rdata, 8'h5C);
        drv_a(0, 0, 0, 0, 0);
        drv_b(0, 0, 0, 0, 0);
        step();
        chk("R8 clash one cycle", {6'd0, a_clash, b_clash}, 0);
        drv_b(1, 0, 0, 9, 0);
        step();
        chk("R6 colliding write landed", b_rdata, 8'h5C);

        // R6 mirrored: B writes 12 while A reads 12
        drv_b(1, 1, 0, 12, 8'h3A);
        drv_a(1, 0, 0, 12, 0);
        step();
        chk("R6 a reader clash", {7'd0, a_clash}, 1);
        chk("R6 b writer not flagged", {7'd0, b_clash}, 0);

        // R7: both ports write location 2
        drv_a(1, 1, 0, 2, 8'h11);
        drv_b(1, 1, 0, 2, 8'h22);
        step();
        chk("R7 dual write clash", {6'd0, a_clash, b_clash}, 2'b11);
        drv_a(0, 0, 0, 0, 0);
        drv_b(0, 0, 0, 0, 0);
        step();
        chk("R8 dual clash one cycle", {6'd0, a_clash, b_clash}, 0);
        drv_a(1, 1, 0, 2, 8'h77);
        step();
        drv_a(0, 0, 0, 0, 0);
        drv_b(1, 0, 0, 2, 0);
        step();
        chk("R7 location rewritable", b_rdata, 8'h77);

        // R9: reset mid-run keeps array
        rst = 1'b1;
        drv_b(0, 0, 0, 0, 0);
        step();
        chk("R9 a_rdata mid reset", a_rdata, 0);
        chk("R9 b_rdata mid reset", b_rdata, 0);
        rst = 1'b0;
        drv_a(1, 0, 0, 9, 0);
        step();
        chk("R9 memory kept over reset", a_rdata, 8'h5C);

        finish_run();
    end
endmodule